// File: doc/BRIEF.md
# SPI Burst Register Access Controller

This block is the serial front end of a register bank. An SPI master lowers the chip select, sends one command byte and then keeps clocking data bytes. The first command bit chooses a write or a read. The low five command bits give the starting register address. After the command, each data byte is written to the addressed register, read from it, or both. The address then steps by one, and after the top register (21) it returns to 0, so long bursts cycle through the whole 22-entry bank.

Some completed bytes also produce single-cycle side-effect strobes. A write to any of the five configuration registers (addresses 0 to 4) raises an abort request for the serial bus engine. A write to the data-low register (address 6) pushes the transmit FIFO. Any access to the data-low register pops the receive FIFO, but only when that FIFO reports data. The register storage, the FIFOs and the bus engine sit outside the block. The block drives a write port and a read address, and it takes read data back.

The whole block runs on SCLK. Reset and a raised chip select both force the sequencer back to idle at once, without waiting for a clock edge.

Top module: `spi_burst_regif`

## Requirements
- R1: While `rst_n` is low, or whenever `cs_n` is high, the sequencer is idle and `miso`, `reg_we`, `abort_req`, `xfifo_push` and `rfifo_pop` are 0. Reset also clears `reg_raddr` to 0.
- R2: Command bit 7, the first bit sent, selects a write (1) or a read (0). A read burst never asserts `reg_we` or `xfifo_push`.
- R3: After the eighth command bit, `reg_raddr` equals command bits [4:0]. Command bits [6:5] have no effect.
- R4: After each completed burst byte, `reg_raddr` advances by one. From 21 it goes to 0.
- R5: A completed write byte pulses `reg_we` for one SCLK cycle. In that cycle `reg_waddr` holds the address the byte was aimed at, before the increment, and `reg_wdata` holds the byte. Bits are received MSB first and sampled on rising SCLK.
- R6: A completed write byte to address 0, 1, 2, 3 or 4 pulses `abort_req`. Writes to other addresses and reads never do.
- R7: A completed write byte to address 6 pulses `xfifo_push`.
- R8: A completed byte at address 6, read or write, pulses `rfifo_pop` when `rx_nempty` is high at the byte's last rising edge. When `rx_nempty` is low, no pop occurs.
- R9: Each strobe (`abort_req`, `xfifo_push`, `rfifo_pop`, `reg_we`) is high for exactly one SCLK cycle per completed byte.
- R10: `miso` is 0 during the command byte. During each burst byte, `miso` carries the addressed register's `reg_rdata`, MSB first, changing on falling SCLK.
- R11: Raising `cs_n` in the middle of a byte discards that byte with no strobe. The next transaction starts cleanly with a new command byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| rx_nempty | input | 1 | Receive FIFO holds at least one entry |
| reg_raddr | output | 5 | Current register pointer, read address |
| reg_rdata | input | 8 | Read data for `reg_raddr` |
| reg_we | output | 1 | Register write strobe |
| reg_waddr | output | 5 | Address of the most recently completed byte |
| reg_wdata | output | 8 | Most recently completed byte |
| abort_req | output | 1 | Abort strobe for configuration writes |
| xfifo_push | output | 1 | Transmit FIFO push strobe |
| rfifo_pop | output | 1 | Receive FIFO pop strobe |

## Verification
A write byte aimed at address 6 while `rx_nempty` is high is the one case where two side effects land in the same SCLK cycle: the transmit push and the receive pop. The stimulus table includes this write next to cases that separate the two strobes: a write to address 6 with the FIFO empty, and reads of address 6 with the FIFO full and with it empty. The bench counts, at every falling edge, the cycles in which both strobes are high. It expects exactly one such cycle for the combined case, and otherwise only the single strobe that the address, direction and FIFO flag call for.

// File: rtl/spi_burst_pkg.sv
`timescale 1ns/1ps
package spi_burst_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_CMD   = 2'd1,
    SEQ_BURST = 2'd2
  } seq_state_e;

  // Register map positions that the side-effect decode depends on
  localparam int unsigned CFG_LAST_ADDR = 4;  // addresses 0..4 are configuration
  localparam int unsigned DLO_ADDR      = 6;  // data-low register

endpackage

// File: rtl/spi_burst_seq.sv
`timescale 1ns/1ps
module spi_burst_seq
  import spi_burst_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned REG_COUNT = 22
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              idle_clr,
  input  logic              mosi,
  output logic              wr_flag,
  output logic              byte_done,
  output logic              at_first,
  output logic [DATA_W-1:0] byte_val,
  output logic [ADDR_W-1:0] ptr
);

  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] CNT_NEXT = CNT_W'(DATA_W - 2);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(REG_COUNT - 1);

  seq_state_e             state;
  logic [CNT_W-1:0]       bitcnt;
  logic [DATA_W-2:0]      shreg;
  logic                   last_bit;
  logic                   cmd_done;

  assign last_bit  = (bitcnt == '0);
  assign byte_val  = {shreg, mosi};
  assign cmd_done  = (state == SEQ_CMD)   && last_bit;
  assign byte_done = (state == SEQ_BURST) && last_bit;
  assign at_first  = (state == SEQ_BURST) && (bitcnt == CNT_TOP);

  // Bit sequencer: forced idle asynchronously by reset or chip select high
  always_ff @(posedge sclk or posedge idle_clr) begin
    if (idle_clr) begin
      state   <= SEQ_IDLE;
      bitcnt  <= CNT_TOP;
      wr_flag <= 1'b0;
      shreg   <= '0;
    end else begin
      shreg <= {shreg[DATA_W-3:0], mosi};
      case (state)
        SEQ_IDLE: begin
          wr_flag <= mosi;
          bitcnt  <= CNT_NEXT;
          state   <= SEQ_CMD;
        end
        SEQ_CMD: begin
          if (last_bit) begin
            bitcnt <= CNT_TOP;
            state  <= SEQ_BURST;
          end else begin
            bitcnt <= bitcnt - 1'b1;
          end
        end
        SEQ_BURST: begin
          if (last_bit) bitcnt <= CNT_TOP;
          else          bitcnt <= bitcnt - 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // Register pointer survives chip select, cleared only by reset
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (cmd_done) begin
      ptr <= byte_val[ADDR_W-1:0];
    end else if (byte_done) begin
      ptr <= (ptr == LAST_ADDR) ? '0 : ptr + 1'b1;
    end
  end

endmodule

// File: rtl/spi_burst_fx.sv
`timescale 1ns/1ps
module spi_burst_fx
  import spi_burst_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              sclk,
  input  logic              idle_clr,
  input  logic              byte_done,
  input  logic              wr_flag,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              rx_nempty,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_waddr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              abort_req,
  output logic              xfifo_push,
  output logic              rfifo_pop
);

  localparam logic [ADDR_W-1:0] CFG_LAST = ADDR_W'(CFG_LAST_ADDR);
  localparam logic [ADDR_W-1:0] DLO      = ADDR_W'(DLO_ADDR);

  logic cfg_sel;
  logic dlo_sel;

  assign cfg_sel = (addr <= CFG_LAST);
  assign dlo_sel = (addr == DLO);

  // Decode uses the address of the byte just completed (pre-increment)
  always_ff @(posedge sclk or posedge idle_clr) begin
    if (idle_clr) begin
      reg_we     <= 1'b0;
      reg_waddr  <= '0;
      reg_wdata  <= '0;
      abort_req  <= 1'b0;
      xfifo_push <= 1'b0;
      rfifo_pop  <= 1'b0;
    end else if (byte_done) begin
      reg_we     <= wr_flag;
      reg_waddr  <= addr;
      reg_wdata  <= data;
      abort_req  <= wr_flag && cfg_sel;
      xfifo_push <= wr_flag && dlo_sel;
      rfifo_pop  <= rx_nempty && dlo_sel;
    end else begin
      reg_we     <= 1'b0;
      abort_req  <= 1'b0;
      xfifo_push <= 1'b0;
      rfifo_pop  <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_burst_tx.sv
`timescale 1ns/1ps
module spi_burst_tx #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              sclk,
  input  logic              idle_clr,
  input  logic              load,
  input  logic [DATA_W-1:0] rdata,
  output logic              miso
);

  logic [DATA_W-1:0] sh;

  // Falling-edge shifter so data is stable at the master's rising sample
  always_ff @(negedge sclk or posedge idle_clr) begin
    if (idle_clr)  sh <= '0;
    else if (load) sh <= rdata;
    else           sh <= {sh[DATA_W-2:0], 1'b0};
  end

  assign miso = sh[DATA_W-1];

endmodule

// File: rtl/spi_burst_regif.sv
`timescale 1ns/1ps
module spi_burst_regif #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned REG_COUNT = 22
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              rx_nempty,
  output logic [ADDR_W-1:0] reg_raddr,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_waddr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              abort_req,
  output logic              xfifo_push,
  output logic              rfifo_pop
);

  logic              idle_clr;
  logic              wr_flag;
  logic              byte_done;
  logic              at_first;
  logic [DATA_W-1:0] byte_val;

  assign idle_clr = ~rst_n | cs_n;

  spi_burst_seq #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .REG_COUNT (REG_COUNT)
  ) u_seq (
    .sclk      (sclk),
    .rst_n     (rst_n),
    .idle_clr  (idle_clr),
    .mosi      (mosi),
    .wr_flag   (wr_flag),
    .byte_done (byte_done),
    .at_first  (at_first),
    .byte_val  (byte_val),
    .ptr       (reg_raddr)
  );

  spi_burst_fx #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_fx (
    .sclk       (sclk),
    .idle_clr   (idle_clr),
    .byte_done  (byte_done),
    .wr_flag    (wr_flag),
    .addr       (reg_raddr),
    .data       (byte_val),
    .rx_nempty  (rx_nempty),
    .reg_we     (reg_we),
    .reg_waddr  (reg_waddr),
    .reg_wdata  (reg_wdata),
    .abort_req  (abort_req),
    .xfifo_push (xfifo_push),
    .rfifo_pop  (rfifo_pop)
  );

  spi_burst_tx #(
    .DATA_W (DATA_W)
  ) u_tx (
    .sclk     (sclk),
    .idle_clr (idle_clr),
    .load     (at_first),
    .rdata    (reg_rdata),
    .miso     (miso)
  );

endmodule

// File: rtl/spi_burst_chk.sv
`timescale 1ns/1ps
module spi_burst_chk #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned REG_COUNT = 22
) (
  input logic              sclk,
  input logic              rst_n,
  input logic              cs_n,
  input logic [ADDR_W-1:0] reg_raddr,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_waddr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              abort_req,
  input logic              xfifo_push,
  input logic              rfifo_pop
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(REG_COUNT - 1);
  localparam logic [ADDR_W-1:0] CFG_LAST  = ADDR_W'(spi_burst_pkg::CFG_LAST_ADDR);
  localparam logic [ADDR_W-1:0] DLO       = ADDR_W'(spi_burst_pkg::DLO_ADDR);

  logic [ADDR_W-1:0] step_addr;
  assign step_addr = (reg_waddr == LAST_ADDR) ? '0 : reg_waddr + 1'b1;

  AST_ABORT_ONE_CYCLE: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    abort_req |=> !abort_req);                                             // R9
  AST_PUSH_ONE_CYCLE: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    xfifo_push |=> !xfifo_push);                                           // R9
  AST_POP_ONE_CYCLE: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    rfifo_pop |=> !rfifo_pop);                                             // R9
  AST_WE_ONE_CYCLE: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    reg_we |=> !reg_we);                                                   // R5
  AST_ABORT_CFG_WRITE: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    abort_req |-> (reg_we && reg_waddr <= CFG_LAST));                      // R6
  AST_PUSH_DLO_WRITE: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    xfifo_push |-> (reg_we && reg_waddr == DLO));                          // R7
  AST_POP_DLO_ADDR: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    rfifo_pop |-> (reg_waddr == DLO));                                     // R8
  AST_PTR_STEP: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    reg_we |-> (reg_raddr == step_addr));                                  // R4
  AST_WDATA_HELD: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    reg_we |=> $stable(reg_wdata));                                        // R5

endmodule

bind spi_burst_regif spi_burst_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .REG_COUNT (REG_COUNT)
) u_chk (
  .sclk       (sclk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .reg_raddr  (reg_raddr),
  .reg_we     (reg_we),
  .reg_waddr  (reg_waddr),
  .reg_wdata  (reg_wdata),
  .abort_req  (abort_req),
  .xfifo_push (xfifo_push),
  .rfifo_pop  (rfifo_pop)
);

// File: tb/tb_spi_burst_regif.sv
`timescale 1ns/1ps
module tb_spi_burst_regif;

  logic       sclk = 1'b0;
  logic       rst_n, cs_n, mosi, rx_nempty;
  logic       miso;
  logic [4:0] reg_raddr, reg_waddr;
  logic [7:0] reg_rdata, reg_wdata;
  logic       reg_we, abort_req, xfifo_push, rfifo_pop;

  always #4 sclk = ~sclk;  // 125 MHz

  spi_burst_regif dut (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .rx_nempty(rx_nempty), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .abort_req(abort_req), .xfifo_push(xfifo_push), .rfifo_pop(rfifo_pop)
  );

  // Bench-side register bank model
  logic [7:0] regs [32];
  assign reg_rdata = regs[reg_raddr];

  int checks = 0, errors = 0;
  int n_abort = 0, n_push = 0, n_pop = 0, n_we = 0, n_coin = 0;
  logic [4:0] last_waddr;
  logic [7:0] last_wdata;

  // Strobe monitor, sampled at falling edges (mid-cycle)
  always @(negedge sclk) begin
    if (abort_req)  n_abort++;
    if (xfifo_push) n_push++;
    if (rfifo_pop)  n_pop++;
    if (xfifo_push && rfifo_pop) n_coin++;
    if (reg_we) begin
      n_we++;
      regs[reg_waddr] = reg_wdata;
      last_waddr = reg_waddr;
      last_wdata = reg_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Entered and left at falling edge + 1 ns
  task automatic send_bits(input logic [7:0] b, input int n, output logic [7:0] rd);
    rd = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = b[i];
      #1 rd[i] = miso;
      @(negedge sclk);
      #1;
    end
  endtask

  task automatic start_x();
    @(negedge sclk);
    #1 cs_n = 1'b0;
  endtask

  task automatic end_x();
    cs_n = 1'b1;
    repeat (2) @(negedge sclk);
    #1;
  endtask

  function automatic logic [4:0] nxt(input logic [4:0] a);
    return (a == 5'd21) ? 5'd0 : a + 5'd1;
  endfunction

  // {cmd[7:0], data[7:0], rx_nempty, exp_abort, exp_push, exp_pop}
  localparam logic [19:0] VEC [10] = '{
    20'h80A54, 20'hE33CC, 20'h845A4, 20'h85118, 20'h86222,
    20'hC633B, 20'h06009, 20'h26000, 20'h02008, 20'h95448
  };

  initial begin
    repeat (50000) @(posedge sclk);
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] cmd, dat, rc, rb, r0, r1, expd;
    logic [4:0] adr;
    int a0, p0, q0, w0, c0;

    for (int i = 0; i < 32; i++) regs[i] = 8'(i * 13 + 7);
    rst_n = 1'b0; cs_n = 1'b1; mosi = 1'b0; rx_nempty = 1'b0;
    repeat (3) @(negedge sclk);
    #1;
    // R1: reset state
    chk({miso, reg_we, abort_req, xfifo_push, rfifo_pop} == 5'b0, "R1 outputs idle in reset",
        {miso, reg_we, abort_req, xfifo_push, rfifo_pop}, 0);
    chk(reg_raddr == 5'd0, "R1 pointer cleared", reg_raddr, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge sclk);
    #1;

    // Table-driven single-byte transactions
    for (int k = 0; k < 10; k++) begin
      cmd = VEC[k][19:12]; dat = VEC[k][11:4]; adr = cmd[4:0];
      rx_nempty = VEC[k][3];
      a0 = n_abort; p0 = n_push; q0 = n_pop; w0 = n_we; c0 = n_coin;
      expd = regs[adr];
      start_x();
      send_bits(cmd, 8, rc);
      chk(reg_raddr == adr, $sformatf("R3 pointer from command v%0d", k), reg_raddr, adr);
      send_bits(dat, 8, rb);
      chk(reg_raddr == nxt(adr), $sformatf("R4 pointer step v%0d", k), reg_raddr, nxt(adr));
      end_x();
      chk(rc == 8'h00, $sformatf("R10 miso idle during command v%0d", k), rc, 0);
      chk(n_abort - a0 == int'(VEC[k][2]), $sformatf("R6 R9 abort count v%0d", k), n_abort - a0, VEC[k][2]);
      chk(n_push - p0 == int'(VEC[k][1]), $sformatf("R7 R9 push count v%0d", k), n_push - p0, VEC[k][1]);
      chk(n_pop - q0 == int'(VEC[k][0]), $sformatf("R8 R9 pop count v%0d", k), n_pop - q0, VEC[k][0]);
      chk(n_coin - c0 == int'(VEC[k][1] & VEC[k][0]), $sformatf("R8 push+pop same cycle v%0d", k),
          n_coin - c0, VEC[k][1] & VEC[k][0]);
      chk(n_we - w0 == int'(cmd[7]), $sformatf("R2 write strobe count v%0d", k), n_we - w0, cmd[7]);
      if (cmd[7]) begin
        chk(last_waddr == adr && last_wdata == dat, $sformatf("R5 write addr/data v%0d", k),
            {last_waddr, last_wdata}, {adr, dat});
      end else begin
        chk(rb == expd, $sformatf("R10 read data v%0d", k), rb, expd);
      end
    end

    // R4: write burst across the wrap point (20, 21, 0)
    rx_nempty = 1'b0;
    a0 = n_abort; w0 = n_we;
    start_x();
    send_bits(8'h94, 8, rc);
    send_bits(8'h61, 8, rb);
    send_bits(8'h62, 8, rb);
    send_bits(8'h63, 8, rb);
    chk(reg_raddr == 5'd1, "R4 pointer after wrap burst", reg_raddr, 1);
    end_x();
    chk(regs[20] == 8'h61 && regs[21] == 8'h62 && regs[0] == 8'h63, "R4 R5 burst writes land in order",
        {regs[20], regs[21], regs[0]}, 24'h616263);
    chk(n_we - w0 == 3, "R5 one write strobe per byte", n_we - w0, 3);
    chk(n_abort - a0 == 1, "R6 abort only for wrapped byte at 0", n_abort - a0, 1);

    // R10: read burst across the wrap point
    start_x();
    send_bits(8'h15, 8, rc);
    send_bits(8'h00, 8, r0);
    send_bits(8'h00, 8, r1);
    end_x();
    chk(r0 == 8'h62 && r1 == 8'h63, "R10 R4 read burst wraps", {r0, r1}, 16'h6263);

    // R11: partial byte dropped by chip select rise
    rx_nempty = 1'b1;
    p0 = n_push; q0 = n_pop; w0 = n_we;
    start_x();
    send_bits(8'h86, 8, rc);
    send_bits(8'hFF, 5, rb);
    end_x();
    chk(n_push == p0 && n_pop == q0 && n_we == w0, "R11 partial byte has no effect",
        n_push - p0 + n_pop - q0 + n_we - w0, 0);
    chk(regs[6] == 8'h33, "R11 register untouched by partial byte", regs[6], 8'h33);
    start_x();
    send_bits(8'h08, 8, rc);
    send_bits(8'h00, 8, rb);
    chk(reg_raddr == 5'd9, "R11 fresh command after abandon", reg_raddr, 9);
    end_x();
    chk(rb == regs[8], "R11 read after abandon", rb, regs[8]);

    // R1: reset in the middle of a configuration write
    a0 = n_abort;
    start_x();
    send_bits(8'h80, 8, rc);
    send_bits(8'hFF, 4, rb);
    rst_n = 1'b0;
    #1;
    chk({miso, reg_we, abort_req} == 3'b0 && reg_raddr == 5'd0, "R1 mid-transfer reset",
        {miso, reg_we, abort_req, reg_raddr}, 0);
    end_x();
    rst_n = 1'b1;
    repeat (2) @(negedge sclk);
    chk(n_abort == a0, "R1 no abort after reset", n_abort - a0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule